// File: doc/BRIEF.md
# Address Parity Error Aggregator

This block gathers address-bus parity error pulses from the three tightly coupled memory ports (A, B0 and B1) of each of several processor cores. Every pulse is held in a sticky raw status bit, and the failing address on that port is captured at the same time. A per-core enable mask turns the raw bits into a masked view. The masked bits of each core are ORed into one registered, glitch-free level interrupt for that core, which goes to the chip's error-signalling module.

Software uses a simple word-addressed register port with a write strobe and a combinational read. Through it, software reads the raw status, the masked status and the captured addresses, and writes the mask. It acknowledges errors through a write-one-to-clear register. It can also inject diagnostic errors through a write-one-to-force register. An injected error enters the detection path before the sticky bit, so it is reported exactly like a real one. The parity checkers themselves sit outside this block; their pulses and addresses arrive as inputs.

Top module: `tcm_apar_agg`

## Requirements
- R1: After reset every raw status bit, every mask bit and every interrupt output is 0.
- R2: Source index s = 3*core + port (port 0 = A, 1 = B0, 2 = B1) maps to raw status bit `port` of that core. The raw register is read at word address 0x10 + 8*core, and input `par_err_i[s]` feeds it.
- R3: A raw bit sets on the clock edge that samples its error pulse, whatever the mask says. It then stays set until it is cleared.
- R4: The mask sits at word 0x12 + 8*core, bits [2:0], and a 1 enables the source. The masked status at word 0x11 + 8*core equals raw AND mask.
- R5: `irq_o[core]` is a registered OR of that core's masked bits. It changes on the same edge as the raw or mask value that causes it, and it never affects another core.
- R6: Writing 1 to bit s of the clear register (word 0x01) clears raw bit s. The interrupt falls on that edge if no other enabled bit remains. Bits written 0 are left untouched.
- R7: An error pulse that arrives in the same cycle as a clear of its bit wins, and the bit stays set.
- R8: The address for source s is read at word 0x14 + 8*core + port. It is taken from `par_addr_i[s*ADDR_W +: ADDR_W]` only when an error hits while the raw bit is clear or being cleared. A later error on a still-set bit leaves it unchanged, and a clear alone does not erase it.
- R9: Writing 1 to bit s of the force register (word 0x00) acts as an error pulse on source s in that cycle. It sets the raw bit, captures the current address input and raises the interrupt if enabled.
- R10: The force and clear registers, and any unmapped word, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| par_err_i | input | NUM_CORES*3 | Parity error pulses, index 3*core+port |
| par_addr_i | input | NUM_CORES*3*ADDR_W | Address seen by each source's checker |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | NUM_CORES | Per-core level interrupt |

## Verification
A table of vectors fires each of the six sources once under a different mask pattern. This shows whether the bit mapping is right, whether raw bits ignore the mask while masked bits and interrupts obey it, and whether an interrupt leaks into the other core. Directed sequences then run the following cases:
- repeated errors on one port, with and without a clear in between, which separates first-error address capture from overwrite behaviour;
- an error in the same cycle as its clear, which shows whether set or clear has priority;
- a forced error with no real pulse present, which shows whether injection enters the detection path;
- read-backs of the action registers.

// File: rtl/apar_pkg.sv
package apar_pkg;
    localparam int PORTS_PER_CORE = 3;

    typedef enum logic [1:0] {
        PORT_A  = 2'd0,
        PORT_B0 = 2'd1,
        PORT_B1 = 2'd2
    } tcm_port_e;

    localparam int OFS_FORCE   = 'h00;
    localparam int OFS_CLEAR   = 'h01;
    localparam int CORE_BASE   = 'h10;
    localparam int CORE_STRIDE = 'h08;
    localparam int SUB_RAW     = 0;
    localparam int SUB_MASKED  = 1;
    localparam int SUB_MASK    = 2;
    localparam int SUB_ADDR    = 4;
endpackage

// File: rtl/apar_port_slot.sv
module apar_port_slot #(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              err_i,
    input  logic              force_i,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              raw_o,
    output logic              raw_next_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic              raw;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    slot_t st_d, st_q;
    logic  hit;

    always_comb begin
        st_d   = st_q;
        hit    = err_i | force_i;
        st_d.raw = (st_q.raw & ~clear_i) | hit;
        if (hit && (!st_q.raw || clear_i)) begin
            st_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o      = st_q.raw;
    assign raw_next_o = st_d.raw;
    assign addr_o     = st_q.addr;
endmodule

// File: rtl/apar_core_ctl.sv
module apar_core_ctl #(
    parameter int NPORT = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPORT-1:0] raw_next_i,
    input  logic             mask_we_i,
    input  logic [NPORT-1:0] mask_wdata_i,
    output logic [NPORT-1:0] mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [NPORT-1:0] mask;
        logic             irq;
    } core_t;

    core_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (mask_we_i) begin
            cs_d.mask = mask_wdata_i;
        end
        cs_d.irq = |(raw_next_i & cs_d.mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign mask_o = cs_q.mask;
    assign irq_o  = cs_q.irq;
endmodule

// File: rtl/apar_regif.sv
module apar_regif
    import apar_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int ADDR_W    = 16,
    parameter int REG_AW    = 8,
    parameter int DATA_W    = 32,
    localparam int NSRC     = NUM_CORES * PORTS_PER_CORE
) (
    input  logic                   we_i,
    input  logic [REG_AW-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [NSRC-1:0]        raw_i,
    input  logic [NSRC-1:0]        mask_i,
    input  logic [NSRC*ADDR_W-1:0] cap_addr_i,
    output logic [NSRC-1:0]        force_o,
    output logic [NSRC-1:0]        clear_o,
    output logic [NUM_CORES-1:0]   mask_we_o,
    output logic [DATA_W-1:0]      rdata_o
);
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:NSRC];

    always_comb begin
        force_o   = '0;
        clear_o   = '0;
        mask_we_o = '0;
        rdata_o   = '0;
        if (we_i && addr_i == REG_AW'(OFS_FORCE)) force_o = wdata_i[NSRC-1:0];
        if (we_i && addr_i == REG_AW'(OFS_CLEAR)) clear_o = wdata_i[NSRC-1:0];
        for (int c = 0; c < NUM_CORES; c++) begin
            if (addr_i == REG_AW'(CORE_BASE + c*CORE_STRIDE + SUB_MASK)) begin
                mask_we_o[c] = we_i;
                rdata_o      = DATA_W'(mask_i[c*PORTS_PER_CORE +: PORTS_PER_CORE]);
            end
            if (addr_i == REG_AW'(CORE_BASE + c*CORE_STRIDE + SUB_RAW)) begin
                rdata_o = DATA_W'(raw_i[c*PORTS_PER_CORE +: PORTS_PER_CORE]);
            end
            if (addr_i == REG_AW'(CORE_BASE + c*CORE_STRIDE + SUB_MASKED)) begin
                rdata_o = DATA_W'(raw_i[c*PORTS_PER_CORE +: PORTS_PER_CORE]
                                  & mask_i[c*PORTS_PER_CORE +: PORTS_PER_CORE]);
            end
            for (int p = 0; p < PORTS_PER_CORE; p++) begin
                if (addr_i == REG_AW'(CORE_BASE + c*CORE_STRIDE + SUB_ADDR + p)) begin
                    rdata_o = DATA_W'(cap_addr_i[(c*PORTS_PER_CORE+p)*ADDR_W +: ADDR_W]);
                end
            end
        end
    end
endmodule

// File: rtl/tcm_apar_agg.sv
module tcm_apar_agg
    import apar_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int ADDR_W    = 16,
    parameter int REG_AW    = 8,
    parameter int DATA_W    = 32,
    localparam int NSRC     = NUM_CORES * PORTS_PER_CORE
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NSRC-1:0]        par_err_i,
    input  logic [NSRC*ADDR_W-1:0] par_addr_i,
    input  logic                   reg_we_i,
    input  logic [REG_AW-1:0]      reg_addr_i,
    input  logic [DATA_W-1:0]      reg_wdata_i,
    output logic [DATA_W-1:0]      reg_rdata_o,
    output logic [NUM_CORES-1:0]   irq_o
);
    logic [NSRC-1:0]        raw_q;
    logic [NSRC-1:0]        raw_next;
    logic [NSRC-1:0]        mask_q;
    logic [NSRC*ADDR_W-1:0] cap_addr_q;
    logic [NSRC-1:0]        force_vec;
    logic [NSRC-1:0]        clear_vec;
    logic [NUM_CORES-1:0]   mask_we;

    apar_regif #(
        .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .REG_AW(REG_AW), .DATA_W(DATA_W)
    ) regif_i (
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .raw_i     (raw_q),
        .mask_i    (mask_q),
        .cap_addr_i(cap_addr_q),
        .force_o   (force_vec),
        .clear_o   (clear_vec),
        .mask_we_o (mask_we),
        .rdata_o   (reg_rdata_o)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_slot
        apar_port_slot #(.ADDR_W(ADDR_W)) slot_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .err_i     (par_err_i[s]),
            .force_i   (force_vec[s]),
            .clear_i   (clear_vec[s]),
            .addr_i    (par_addr_i[s*ADDR_W +: ADDR_W]),
            .raw_o     (raw_q[s]),
            .raw_next_o(raw_next[s]),
            .addr_o    (cap_addr_q[s*ADDR_W +: ADDR_W])
        );
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        apar_core_ctl #(.NPORT(PORTS_PER_CORE)) core_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .raw_next_i  (raw_next[c*PORTS_PER_CORE +: PORTS_PER_CORE]),
            .mask_we_i   (mask_we[c]),
            .mask_wdata_i(reg_wdata_i[PORTS_PER_CORE-1:0]),
            .mask_o      (mask_q[c*PORTS_PER_CORE +: PORTS_PER_CORE]),
            .irq_o       (irq_o[c])
        );
    end
endmodule

// File: rtl/apar_checker.sv
module apar_checker #(
    parameter int NUM_CORES = 2,
    parameter int ADDR_W    = 16,
    parameter int REG_AW    = 8,
    parameter int DATA_W    = 32,
    localparam int NSRC     = NUM_CORES * 3
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [NSRC-1:0]        par_err_i,
    input logic [REG_AW-1:0]      reg_addr_i,
    input logic [DATA_W-1:0]      reg_rdata_o,
    input logic [NUM_CORES-1:0]   irq_o,
    input logic [NSRC-1:0]        raw_q,
    input logic [NSRC-1:0]        mask_q,
    input logic [NSRC*ADDR_W-1:0] cap_addr_q,
    input logic [NSRC-1:0]        force_vec,
    input logic [NSRC-1:0]        clear_vec
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
        assert_irq_or_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[c] == |(raw_q[c*3 +: 3] & mask_q[c*3 +: 3]));
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src_chk
        assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (raw_q[s] && !clear_vec[s]) |=> raw_q[s]);
        assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (par_err_i[s] || force_vec[s]) |=> raw_q[s]);
        assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (raw_q[s] && !clear_vec[s]) |=> $stable(cap_addr_q[s*ADDR_W +: ADDR_W]));
    end

    assert_action_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == REG_AW'(0) || reg_addr_i == REG_AW'(1)) |-> reg_rdata_o == '0);
endmodule

bind tcm_apar_agg apar_checker #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .REG_AW(REG_AW), .DATA_W(DATA_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .par_err_i  (par_err_i),
    .reg_addr_i (reg_addr_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o),
    .raw_q      (raw_q),
    .mask_q     (mask_q),
    .cap_addr_q (cap_addr_q),
    .force_vec  (force_vec),
    .clear_vec  (clear_vec)
);

// File: tb/tcm_apar_agg_tb.sv
module tcm_apar_agg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC   = 2;
    localparam int AW   = 16;
    localparam int RAW  = 8;
    localparam int DW   = 32;
    localparam int NSRC = NC * 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   par_err = '0;
    logic [NSRC*AW-1:0] par_addr = '0;
    logic              we = 1'b0;
    logic [RAW-1:0]    addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic [NC-1:0]     irq;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcm_apar_agg #(.NUM_CORES(NC), .ADDR_W(AW), .REG_AW(RAW), .DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .par_err_i(par_err), .par_addr_i(par_addr),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [1:0] core;
        logic [1:0] port;
        logic [2:0] mask;
        logic [2:0] exp_raw;
        logic [2:0] exp_msk;
        logic [1:0] exp_irq;
    } vec_t;

    localparam logic [14:0] VECS [6] = '{
        {2'd0, 2'd0, 3'b111, 3'b001, 3'b001, 2'b01},
        {2'd0, 2'd1, 3'b001, 3'b010, 3'b000, 2'b00},
        {2'd0, 2'd2, 3'b100, 3'b100, 3'b100, 2'b01},
        {2'd1, 2'd0, 3'b000, 3'b001, 3'b000, 2'b00},
        {2'd1, 2'd1, 3'b010, 3'b010, 3'b010, 2'b10},
        {2'd1, 2'd2, 3'b011, 3'b100, 3'b000, 2'b00}
    };

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = RAW'(a); wdata = d;
        @(negedge clk);
        we = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        addr = RAW'(a);
        #1 d = rdata;
        addr = '0;
    endtask

    task automatic set_addr(input int s, input logic [AW-1:0] a);
        par_addr[s*AW +: AW] = a;
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        par_err[s] = 1'b1;
        @(negedge clk);
        par_err = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd('h10, rv); chk("R1 raw core0", rv, 0);
        rd('h18, rv); chk("R1 raw core1", rv, 0);
        rd('h12, rv); chk("R1 mask core0", rv, 0);
        chk("R1 irq", DW'(irq), 0);

        // R2 R3 R4 R5 table walk
        for (int i = 0; i < 6; i++) begin
            v = vec_t'(VECS[i]);
            wr('h01, DW'({NSRC{1'b1}}));
            wr('h12, (v.core == 0) ? DW'(v.mask) : 0);
            wr('h1A, (v.core == 1) ? DW'(v.mask) : 0);
            pulse(int'(v.core) * 3 + int'(v.port));
            rd('h10 + 8 * int'(v.core), rv); chk($sformatf("R2 R3 raw vec%0d", i), rv, DW'(v.exp_raw));
            rd('h11 + 8 * int'(v.core), rv); chk($sformatf("R4 masked vec%0d", i), rv, DW'(v.exp_msk));
            chk($sformatf("R5 irq vec%0d", i), DW'(irq), DW'(v.exp_irq));
        end

        // R5 enable mask after a latched error raises irq on the mask write edge
        wr('h01, DW'({NSRC{1'b1}}));
        wr('h12, 0); wr('h1A, 0);
        pulse(1);
        chk("R5 irq masked off", DW'(irq), 0);
        wr('h12, 3'b010);
        chk("R5 irq after enable", DW'(irq), 2'b01);

        // R6 clear one bit, others untouched
        pulse(0);
        wr('h12, 3'b011);
        wr('h01, 6'b000010);
        rd('h10, rv); chk("R6 partial clear raw", rv, 3'b001);
        chk("R6 irq stays", DW'(irq), 2'b01);
        wr('h01, 6'b000001);
        chk("R6 irq drops", DW'(irq), 0);

        // R8 address capture on first error only
        set_addr(0, 16'h1234);
        pulse(0);
        set_addr(0, 16'h5678);
        pulse(0);
        rd('h14, rv); chk("R8 first address kept", rv, 16'h1234);
        wr('h01, 6'b000001);
        rd('h14, rv); chk("R8 clear keeps address", rv, 16'h1234);
        set_addr(0, 16'h9ABC);
        pulse(0);
        rd('h14, rv); chk("R8 recapture after clear", rv, 16'h9ABC);

        // R7 error coincident with clear wins, and R8 captures the new address
        set_addr(0, 16'hBEEF);
        @(negedge clk);
        par_err[0] = 1'b1; we = 1'b1; addr = 'h01; wdata = 6'b000001;
        @(negedge clk);
        par_err = '0; we = 1'b0; addr = '0; wdata = '0;
        rd('h10, rv); chk("R7 set wins over clear", rv, 3'b001);
        rd('h14, rv); chk("R8 capture with clear", rv, 16'hBEEF);

        // R9 forced error on core1 port B1
        wr('h01, DW'({NSRC{1'b1}}));
        wr('h1A, 3'b111);
        set_addr(5, 16'h0F0F);
        wr('h00, 6'b100000);
        rd('h18, rv); chk("R9 forced raw", rv, 3'b100);
        rd('h1E, rv); chk("R9 forced address", rv, 16'h0F0F);
        chk("R9 forced irq", DW'(irq), 2'b10);

        // R10 action registers and unmapped word read zero
        rd('h00, rv); chk("R10 force reads zero", rv, 0);
        rd('h01, rv); chk("R10 clear reads zero", rv, 0);
        rd('h03, rv); chk("R10 unmapped reads zero", rv, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule